// File: doc/BRIEF.md
# Recursive Two-Dimensional Sliding DFT Bin

This block tracks a single spectral bin of a two-dimensional discrete Fourier transform taken over a window of `ROWS` × `COLS` complex samples. The samples arrive one at a time in column-major order: the row index advances fastest, and a column is complete after `ROWS` samples. The block does not recompute the transform for each sample. It updates a complex fixed-point accumulator with each accepted sample. The update input is the difference between the new sample and the sample at the same row position `COLS` columns earlier. That older sample is held in a circular store of `ROWS·COLS` entries, which reset clears to zero.

The accumulator is rotated with one of two rotation factors. Inside a column it is multiplied by the column factor e^{+j2π·k1/N1}, and the difference is multiplied by the joint factor e^{+j2π(k1/N1+k2/N2)}. On the first row of a new column, the accumulator and the difference are added first, and the sum is multiplied by the joint factor. Every update uses four real products. Each product is rounded on its own; the sums are exact. Both rotation factors are constants, computed when the block is elaborated from the bin indices `FREQ_ROW` and `FREQ_COL`.

The bin value appears on the output one cycle after each accepted sample. A valid strobe qualifies it once a full window has been collected.

Top module: `sdft_bin`

## Requirements
- R1: During and after reset, `bin_valid` is 0 and `bin_re` and `bin_im` are 0 until the first sample is accepted.
- R2: `bin_valid` stays low until the cycle after the `ROWS·COLS`-th sample accepted since reset. It first rises in exactly that cycle.
- R3: Once the window is full, `bin_valid` is 1 in the cycle after each cycle with `in_valid` high. It is 0 in the cycle after each cycle with `in_valid` low.
- R4: A cycle with `in_valid` low changes neither the bin value nor the row/column position of the next sample.
- R5: Take the last accepted sample at row `ROWS-1`, so that it ends a column. The bin then equals Σ x(r,q)·e^{-j2π(k1·r/N1 + k2·q/N2)} over the last `ROWS·COLS` samples. Here r is the row and q is the column within the window, with q = 0 for the oldest column. Samples and bin values are `DW`-bit two's complement with `DW-1` fraction bits.
- R6: After a sample at row n and column c (both counted from reset, row index fastest), the bin equals Σ x(r,m)·e^{+j2π(k1(n+1-r)/N1 + k2(c-m+1)/N2)}. The sum runs over the last `ROWS·COLS` samples, with samples before reset taken as zero. A row-0 sample applies the joint factor to (accumulator + difference). Any other row applies the column factor to the accumulator and the joint factor to the difference.
- R7: A sample leaves no residue once it is older than the window. When every coefficient is exactly representable, `ROWS·COLS` zero samples bring the bin to exactly 0.
- R8: While every complex input has magnitude below 1/(`ROWS·COLS`), no update sum leaves the `DW`-bit range. An input whose phases are aligned to the bin builds a bin of magnitude `ROWS·COLS`·|x|.
- R9: Each real product is rounded to `DW-1` fraction bits, to nearest, with ties away from zero. A single sample from rest therefore gives a bin within half an LSB of the exact value, plus coefficient quantisation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the accumulator, the sample store and the position |
| in_valid | input | 1 | Accepts `in_re`/`in_im` as the next sample in this cycle |
| in_re | input | DW | Real part of the sample, signed fraction |
| in_im | input | DW | Imaginary part of the sample, signed fraction |
| bin_valid | output | 1 | The bin reflects a full window and was updated in the previous cycle |
| bin_re | output | DW | Real part of the bin |
| bin_im | output | DW | Imaginary part of the bin |

## Verification
The bench drives two instances with the same stream. The first is a 4×4 window at bin (1,1). Its rotation factors are 0 and ±1, so every product is exact, and the bin must match the closed-form sums of R5 and R6 bit for bit. Any error in the update ordering, the column-wrap selection or the difference store therefore shows up as a mismatch. The second is an 8×2 window at bin (3,1). Its factors fall at odd multiples of π/4, which brings rounding direction and coefficient quantisation within reach. Its first sample from rest is held to a sub-LSB bound, and later samples are held to a tolerance that grows with the number of updates.

// File: rtl/sdft_pkg.sv
package sdft_pkg;

  typedef enum logic {
    UPD_COLUMN = 1'b0,
    UPD_WRAP   = 1'b1
  } upd_mode_e;

  // Arithmetic right shift by sh with round-to-nearest, ties away from zero.
  function automatic logic signed [63:0] round_shift(input logic signed [63:0] p,
                                                     input int sh);
    logic signed [63:0] half;
    logic signed [63:0] mag;
    half = 64'sd1 <<< (sh - 1);
    if (p < 0) begin
      mag = -p;
      round_shift = -((mag + half) >>> sh);
    end else begin
      round_shift = (p + half) >>> sh;
    end
  endfunction

  // Product of a data word and a coefficient, brought back to the data scale.
  function automatic logic signed [63:0] scaled_product(input logic signed [63:0] a,
                                                        input logic signed [63:0] c,
                                                        input int sh);
    scaled_product = round_shift(a * c, sh);
  endfunction

  // Elaboration-time sine or cosine of 2*pi*num/den by a power series.
  function automatic real series_trig(input int num, input int den, input bit want_sin);
    real ang;
    real x2;
    real term;
    real acc;
    ang = 2.0 * 3.14159265358979323846 * real'(num % den) / real'(den);
    if (ang > 3.14159265358979323846) ang = ang - 2.0 * 3.14159265358979323846;
    x2 = ang * ang;
    if (want_sin) begin
      term = ang;
      acc  = ang;
      for (int i = 1; i < 16; i++) begin
        term = -term * x2 / real'((2 * i) * (2 * i + 1));
        acc  = acc + term;
      end
    end else begin
      term = 1.0;
      acc  = 1.0;
      for (int i = 1; i < 16; i++) begin
        term = -term * x2 / real'((2 * i - 1) * (2 * i));
        acc  = acc + term;
      end
    end
    series_trig = acc;
  endfunction

  // Quantised coefficient with frac fraction bits, rounded to nearest.
  function automatic int quant_trig(input int num, input int den, input bit want_sin,
                                    input int frac);
    real scale;
    real v;
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    v = series_trig(num, den, want_sin) * scale;
    if (v >= 0.0) quant_trig = $rtoi(v + 0.5);
    else          quant_trig = -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/sdft_index_ctrl.sv
module sdft_index_ctrl
  import sdft_pkg::*;
#(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  output upd_mode_e mode,
  output logic      first_pass,
  output logic      emit
);

  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(DEPTH - 1);

  logic [ROW_W-1:0]  row_q;
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      fill_q <= '0;
    end else if (accept) begin
      row_q <= (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
      if (fill_q != FILL_FULL) fill_q <= fill_q + FILL_W'(1);
    end
  end

  // A sample at row 0 opens a new column: the joint factor applies to acc + diff.
  assign mode       = (row_q == '0) ? UPD_WRAP : UPD_COLUMN;
  assign first_pass = (fill_q != FILL_FULL);
  assign emit       = accept && (fill_q >= FILL_LAST);

  AST_FILL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !first_pass |=> !first_pass); // R2

endmodule

// File: rtl/sdft_delay_line.sv
module sdft_delay_line #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [DW-1:0] new_re,
  input  logic signed [DW-1:0] new_im,
  output logic signed [DW-1:0] old_re,
  output logic signed [DW-1:0] old_im
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic signed [DW-1:0] slot_re [DEPTH];
  logic signed [DW-1:0] slot_im [DEPTH];
  logic [PTR_W-1:0]     wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_re[g] <= '0;
        slot_im[g] <= '0;
      end else if (push && (wr_ptr == PTR_W'(g))) begin
        slot_re[g] <= new_re;
        slot_im[g] <= new_im;
      end
    end
  end

  // The slot about to be overwritten holds the sample one full window back.
  assign old_re = slot_re[wr_ptr];
  assign old_im = slot_im[wr_ptr];

endmodule

// File: rtl/sdft_coef_sel.sv
module sdft_coef_sel
  import sdft_pkg::*;
#(
  parameter int unsigned ROWS     = 4,
  parameter int unsigned COLS     = 4,
  parameter int unsigned FREQ_ROW = 1,
  parameter int unsigned FREQ_COL = 1,
  parameter int unsigned CW       = 18,
  parameter int unsigned CF       = 16
) (
  input  upd_mode_e            mode,
  output logic signed [CW-1:0] rot_cos,
  output logic signed [CW-1:0] rot_sin,
  output logic signed [CW-1:0] mix_cos,
  output logic signed [CW-1:0] mix_sin
);

  localparam int unsigned SPAN       = ROWS * COLS;
  localparam int unsigned COL_STEP   = (FREQ_ROW * COLS) % SPAN;
  localparam int unsigned JOINT_STEP = (FREQ_ROW * COLS + FREQ_COL * ROWS) % SPAN;

  localparam logic signed [CW-1:0] COL_C = CW'(quant_trig(COL_STEP, SPAN, 1'b0, CF));
  localparam logic signed [CW-1:0] COL_S = CW'(quant_trig(COL_STEP, SPAN, 1'b1, CF));
  localparam logic signed [CW-1:0] JNT_C = CW'(quant_trig(JOINT_STEP, SPAN, 1'b0, CF));
  localparam logic signed [CW-1:0] JNT_S = CW'(quant_trig(JOINT_STEP, SPAN, 1'b1, CF));

  always_comb begin
    mix_cos = JNT_C;
    mix_sin = JNT_S;
    if (mode == UPD_WRAP) begin
      rot_cos = JNT_C;
      rot_sin = JNT_S;
    end else begin
      rot_cos = COL_C;
      rot_sin = COL_S;
    end
  end

endmodule

// File: rtl/sdft_rotator.sv
module sdft_rotator
  import sdft_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 18,
  parameter int unsigned CF = 16
) (
  input  logic signed [DW-1:0] acc_re,
  input  logic signed [DW-1:0] acc_im,
  input  logic signed [DW:0]   dif_re,
  input  logic signed [DW:0]   dif_im,
  input  logic signed [CW-1:0] rot_cos,
  input  logic signed [CW-1:0] rot_sin,
  input  logic signed [CW-1:0] mix_cos,
  input  logic signed [CW-1:0] mix_sin,
  output logic signed [DW-1:0] nxt_re,
  output logic signed [DW-1:0] nxt_im,
  output logic                 overflow
);

  localparam logic signed [63:0] LIM_HI = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam logic signed [63:0] LIM_LO = -(64'sd1 <<< (DW - 1));

  logic signed [63:0] sum_re;
  logic signed [63:0] sum_im;

  always_comb begin
    sum_re = scaled_product(64'(acc_re), 64'(rot_cos), CF)
           - scaled_product(64'(acc_im), 64'(rot_sin), CF)
           + scaled_product(64'(dif_re), 64'(mix_cos), CF)
           - scaled_product(64'(dif_im), 64'(mix_sin), CF);
    sum_im = scaled_product(64'(acc_re), 64'(rot_sin), CF)
           + scaled_product(64'(acc_im), 64'(rot_cos), CF)
           + scaled_product(64'(dif_re), 64'(mix_sin), CF)
           + scaled_product(64'(dif_im), 64'(mix_cos), CF);
  end

  assign overflow = (sum_re > LIM_HI) || (sum_re < LIM_LO) ||
                    (sum_im > LIM_HI) || (sum_im < LIM_LO);
  assign nxt_re = sum_re[DW-1:0];
  assign nxt_im = sum_im[DW-1:0];

endmodule

// File: rtl/sdft_bin.sv
module sdft_bin
  import sdft_pkg::*;
#(
  parameter int unsigned ROWS     = 4,
  parameter int unsigned COLS     = 4,
  parameter int unsigned FREQ_ROW = 1,
  parameter int unsigned FREQ_COL = 1,
  parameter int unsigned DW       = 16,
  parameter int unsigned CW       = 18,
  parameter int unsigned CF       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 bin_valid,
  output logic signed [DW-1:0] bin_re,
  output logic signed [DW-1:0] bin_im
);

  localparam int unsigned DEPTH = ROWS * COLS;

  upd_mode_e            mode;
  logic                 first_pass;
  logic                 emit;
  logic signed [DW-1:0] old_re;
  logic signed [DW-1:0] old_im;
  logic signed [DW:0]   dif_re;
  logic signed [DW:0]   dif_im;
  logic signed [CW-1:0] rot_cos;
  logic signed [CW-1:0] rot_sin;
  logic signed [CW-1:0] mix_cos;
  logic signed [CW-1:0] mix_sin;
  logic signed [DW-1:0] acc_re;
  logic signed [DW-1:0] acc_im;
  logic signed [DW-1:0] nxt_re;
  logic signed [DW-1:0] nxt_im;
  logic                 sum_ovf;

  sdft_index_ctrl #(.ROWS(ROWS), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (in_valid),
    .mode       (mode),
    .first_pass (first_pass),
    .emit       (emit)
  );

  sdft_delay_line #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (in_valid),
    .new_re (in_re),
    .new_im (in_im),
    .old_re (old_re),
    .old_im (old_im)
  );

  sdft_coef_sel #(
    .ROWS(ROWS), .COLS(COLS), .FREQ_ROW(FREQ_ROW), .FREQ_COL(FREQ_COL), .CW(CW), .CF(CF)
  ) u_coef (
    .mode    (mode),
    .rot_cos (rot_cos),
    .rot_sin (rot_sin),
    .mix_cos (mix_cos),
    .mix_sin (mix_sin)
  );

  // Sliding difference: new sample minus the one a full window earlier.
  assign dif_re = (DW+1)'(in_re) - (DW+1)'(old_re);
  assign dif_im = (DW+1)'(in_im) - (DW+1)'(old_im);

  sdft_rotator #(.DW(DW), .CW(CW), .CF(CF)) u_rot (
    .acc_re   (acc_re),
    .acc_im   (acc_im),
    .dif_re   (dif_re),
    .dif_im   (dif_im),
    .rot_cos  (rot_cos),
    .rot_sin  (rot_sin),
    .mix_cos  (mix_cos),
    .mix_sin  (mix_sin),
    .nxt_re   (nxt_re),
    .nxt_im   (nxt_im),
    .overflow (sum_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re    <= '0;
      acc_im    <= '0;
      bin_valid <= 1'b0;
    end else begin
      bin_valid <= emit;
      if (in_valid) begin
        acc_re <= nxt_re;
        acc_im <= nxt_im;
      end
    end
  end

  assign bin_re = acc_re;
  assign bin_im = acc_im;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !sum_ovf); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(bin_re) && $stable(bin_im)); // R4

  AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> !first_pass); // R2

  AST_VALID_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> $past(in_valid)); // R3

  AST_FIRST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_pass) |-> (old_re == '0) && (old_im == '0)); // R7

endmodule

// File: tb/sdft_bin_test.sv
`timescale 1ns/1ps
module sdft_bin_test;

  localparam int DW = 16;
  localparam real PI = 3.14159265358979323846;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 v_a, v_b;
  logic signed [DW-1:0] re_a, im_a, re_b, im_b;

  int checks = 0;
  int fails = 0;
  int n_pushed = 0;
  int hist_re [0:511];
  int hist_im [0:511];

  always #2 clk = ~clk;

  sdft_bin #(.ROWS(4), .COLS(4), .FREQ_ROW(1), .FREQ_COL(1), .DW(DW), .CW(18), .CF(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .bin_valid(v_a), .bin_re(re_a), .bin_im(im_a));

  sdft_bin #(.ROWS(8), .COLS(2), .FREQ_ROW(3), .FREQ_COL(1), .DW(DW), .CW(18), .CF(16)) uut_fine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .bin_valid(v_b), .bin_re(re_b), .bin_im(im_b));

  task automatic check_num(input string req, input string what, input real act,
                           input real exp, input real tol);
    checks++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input string what, input logic act,
                           input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Phase-rotated sliding sum (R6) over the last rows*cols samples.
  function automatic void model_rot(input int rows, input int cols, input int kr, input int kc,
                                    output real er, output real ei);
    int s;
    int row_now;
    int col_now;
    s = n_pushed - 1;
    row_now = s % rows;
    col_now = s / rows;
    er = 0.0;
    ei = 0.0;
    for (int t = s - rows * cols + 1; t <= s; t++) begin
      if (t >= 0) begin
        int r;
        int m;
        real ph;
        r = t % rows;
        m = t / rows;
        ph = 2.0 * PI * (real'(kr * (row_now + 1 - r)) / real'(rows) +
                         real'(kc * (col_now - m + 1)) / real'(cols));
        er = er + hist_re[t] * $cos(ph) - hist_im[t] * $sin(ph);
        ei = ei + hist_re[t] * $sin(ph) + hist_im[t] * $cos(ph);
      end
    end
  endfunction

  // Plain forward DFT of a window that ends on a column boundary (R5).
  function automatic void model_dft(input int rows, input int cols, input int kr, input int kc,
                                    output real er, output real ei);
    int s;
    int first_col;
    s = n_pushed - 1;
    first_col = s / rows - cols + 1;
    er = 0.0;
    ei = 0.0;
    for (int t = s - rows * cols + 1; t <= s; t++) begin
      if (t >= 0) begin
        int r;
        int q;
        real ph;
        r = t % rows;
        q = t / rows - first_col;
        ph = -2.0 * PI * (real'(kr * r) / real'(rows) + real'(kc * q) / real'(cols));
        er = er + hist_re[t] * $cos(ph) - hist_im[t] * $sin(ph);
        ei = ei + hist_re[t] * $sin(ph) + hist_im[t] * $cos(ph);
      end
    end
  endfunction

  function automatic real fine_tol();
    return 0.6 + 4.0 * real'(n_pushed - 1);
  endfunction

  task automatic compare_bins(input string req);
    real er, ei;
    model_rot(4, 4, 1, 1, er, ei);
    check_num(req, "exact bin re", real'(re_a), er, 0.01);
    check_num(req, "exact bin im", real'(im_a), ei, 0.01);
    model_rot(8, 2, 3, 1, er, ei);
    check_num(req, "fine bin re", real'(re_b), er, fine_tol());
    check_num(req, "fine bin im", real'(im_b), ei, fine_tol());
    if (n_pushed % 4 == 0) begin
      model_dft(4, 4, 1, 1, er, ei);
      check_num("R5", "exact column-end re", real'(re_a), er, 0.01);
      check_num("R5", "exact column-end im", real'(im_a), ei, 0.01);
    end
    if (n_pushed % 8 == 0) begin
      model_dft(8, 2, 3, 1, er, ei);
      check_num("R5", "fine column-end re", real'(re_b), er, fine_tol());
      check_num("R5", "fine column-end im", real'(im_b), ei, fine_tol());
    end
  endtask

  // Drive one sample at a falling edge, check one cycle later at the next falling edge.
  task automatic push(input int xr, input int xi, input string req_v, input string req_d);
    hist_re[n_pushed] = xr;
    hist_im[n_pushed] = xi;
    n_pushed++;
    in_valid = 1'b1;
    in_re = DW'(xr);
    in_im = DW'(xi);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(req_v, "exact bin_valid", v_a, n_pushed >= 16);
    check_bit(req_v, "fine bin_valid", v_b, n_pushed >= 16);
    compare_bins(req_d);
  endtask

  task automatic idle(input int cycles);
    logic signed [DW-1:0] hold_a, hold_b;
    hold_a = re_a;
    hold_b = im_b;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_bit("R3", "bin_valid in idle", v_a, 1'b0);
      check_num("R4", "exact bin re held", real'(re_a), real'(hold_a), 0.0);
      check_num("R4", "fine bin im held", real'(im_b), real'(hold_b), 0.0);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_pushed = 0;
    @(negedge clk);
  endtask

  function automatic int pat(input int i, input int salt);
    return ((i * 7919 + salt * 104729) % 2801) - 1400;
  endfunction

  task automatic t_reset();
    apply_reset();
    check_bit("R1", "exact bin_valid after reset", v_a, 1'b0);
    check_bit("R1", "fine bin_valid after reset", v_b, 1'b0);
    check_num("R1", "exact re after reset", real'(re_a), 0.0, 0.0);
    check_num("R1", "exact im after reset", real'(im_a), 0.0, 0.0);
    check_num("R1", "fine re after reset", real'(re_b), 0.0, 0.0);
  endtask

  task automatic t_round();
    push(-1000, 0, "R2", "R9");
    apply_reset();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) push(pat(i, 1), pat(i, 2), "R2", "R6");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 20; i++) push(pat(i, 3), pat(i, 4), "R3", "R6");
  endtask

  task automatic t_gaps();
    push(pat(1, 5), pat(2, 5), "R3", "R4");
    idle(3);
    push(pat(3, 5), pat(4, 5), "R3", "R4");
    idle(1);
    push(pat(5, 5), pat(6, 5), "R3", "R4");
    push(pat(7, 5), pat(8, 5), "R3", "R4");
    idle(2);
    push(pat(9, 5), pat(10, 5), "R3", "R4");
  endtask

  task automatic t_drain();
    for (int i = 0; i < 16; i++) push(0, 0, "R3", "R7");
    check_num("R7", "exact bin re after zero window", real'(re_a), 0.0, 0.0);
    check_num("R7", "exact bin im after zero window", real'(im_a), 0.0, 0.0);
  endtask

  task automatic t_extreme();
    real mag;
    apply_reset();
    for (int t = 0; t < 16; t++) begin
      real th;
      th = 2.0 * PI * (real'(t % 4) / 4.0 + real'(t / 4) / 4.0);
      push($rtoi($cos(th) * 1400.0 + ($cos(th) >= 0.0 ? 0.5 : -0.5)),
           $rtoi($sin(th) * 1400.0 + ($sin(th) >= 0.0 ? 0.5 : -0.5)), "R2", "R8");
    end
    mag = $sqrt(real'(re_a) * real'(re_a) + real'(im_a) * real'(im_a));
    check_num("R8", "aligned full-scale magnitude", mag, 22400.0, 1.0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_round();
    t_fill();
    t_stream();
    t_gaps();
    t_drain();
    t_extreme();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule